// File: doc/BRIEF.md
# Aligned Equal-Size Transfer Segment Splitter

This block turns one scatter entry, a start address plus a byte count, into a stream of segment descriptors that a transfer engine with a limited per-load count can use directly. Each segment is no longer than the engine's maximum count. Every segment except the final one is a multiple of four bytes, so the next segment start stays word aligned. When the remaining length is too large for one load, the block first works out how many pieces are needed and then cuts the next piece as an even share of the remainder. Because of this the stream never ends in a small tail segment.

A request is taken over a valid/ready handshake. The block then recomputes the piece count and the share for every segment from the current remainder, using one shared bit-serial divider. While it divides or waits for the consumer, the block holds off new requests. If a request starts at an address that is not word aligned, it is refused: the block raises a one-cycle error flag and emits nothing. A zero-length request is accepted and dropped.

Top module: `seg_splitter`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and err_misalign is 0.
- R2: A request accepted with in_addr[1:0] not equal to 0 raises err_misalign for exactly the one cycle after the accepting edge. It produces no segment, and in_ready stays 1.
- R3: A request accepted with in_len equal to 0 produces no segment, and in_ready stays 1.
- R4: If the remaining length is at most 0x1FFF, the whole remainder is emitted as one segment with out_last set to 1.
- R5: If the remaining length r exceeds 0x1FFF, the segment length is (r / ceil(r / 0x1FFC)) with bits 1:0 cleared, and out_last is 0.
- R6: The first segment starts at in_addr. Each later segment starts at the previous address plus the previous length, and the lengths add up to in_len.
- R7: in_ready is 0 from the edge that accepts a non-empty aligned request until the edge that transfers the segment with out_last set. out_last is 1 only on that final segment.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_addr, out_len and out_last hold their values into the next cycle.
- R9: Every emitted segment has a length between 1 and 0x1FFF. Every non-final segment has bits 1:0 of both its length and its address equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_addr | input | 32 | Request start byte address |
| in_len | input | 16 | Request byte count |
| out_valid | output | 1 | Segment descriptor present |
| out_ready | input | 1 | Consumer takes the segment |
| out_addr | output | 32 | Segment start address |
| out_len | output | 16 | Segment byte count |
| out_last | output | 1 | Segment completes the request |
| err_misalign | output | 1 | One-cycle pulse for a refused misaligned request |

## Verification
Two functions can fall in the same cycle: the error pulse for a refused misaligned request, and the acceptance of the next request. The pulse comes one cycle after the bad request, and at that point the block is already idle again. The bench presents a misaligned request and then, in the very next cycle, a valid one. It checks that the flag is raised exactly once, that no segment comes from the bad request, and that the valid request still produces its full segment sequence from its own address. Randomised backpressure on out_ready is applied to every segment so that the hold rule and the final-segment handshake are both exercised.

// File: rtl/seg_splitter.sv
module seg_splitter #(
  parameter int AW         = 32,
  parameter int LW         = 16,
  parameter int MAX_SEG    = 8191,
  parameter int ALIGN_BITS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [LW-1:0] in_len,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [LW-1:0] out_len,
  output logic          out_last,
  output logic          err_misalign
);

  localparam int DW     = LW + 1;
  localparam int CW     = $clog2(DW + 1);
  localparam int CHUNK  = MAX_SEG - (MAX_SEG % (1 << ALIGN_BITS));
  localparam logic [LW-1:0] AMASK = LW'((1 << ALIGN_BITS) - 1);
  localparam logic [DW-1:0] MAXD  = DW'(MAX_SEG);
  localparam logic [DW-1:0] CHD   = DW'(CHUNK);

  typedef enum logic [2:0] {ST_IDLE, ST_PLAN, ST_CNT, ST_QUO, ST_OUT} st_t;

  st_t           st;
  logic [AW-1:0] cur_addr;
  logic [LW-1:0] rem;
  logic [LW-1:0] seg;
  logic [DW-1:0] dv_n, dv_r, dv_d;
  logic [CW-1:0] dv_cnt;
  logic          err_q;

  logic [DW-1:0] trial, r_nx, q_nx;
  logic          take, fits, bad_addr, accept, div_done;

  assign trial    = {dv_r[DW-2:0], dv_n[DW-1]};
  assign take     = trial >= dv_d;
  assign r_nx     = take ? trial - dv_d : trial;
  assign q_nx     = {dv_n[DW-2:0], take};
  assign div_done = dv_cnt == CW'(1);
  assign fits     = {1'b0, rem} <= MAXD;
  assign bad_addr = in_addr[ALIGN_BITS-1:0] != '0;
  assign accept   = in_valid && in_ready;

  assign in_ready     = st == ST_IDLE;
  assign out_valid    = st == ST_OUT;
  assign out_addr     = cur_addr;
  assign out_len      = seg;
  assign out_last     = seg == rem;
  assign err_misalign = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      rem      <= '0;
      seg      <= '0;
      dv_n     <= '0;
      dv_r     <= '0;
      dv_d     <= '0;
      dv_cnt   <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= accept && bad_addr;
      case (st)
        ST_IDLE: begin
          if (accept && !bad_addr && in_len != '0) begin
            cur_addr <= in_addr;
            rem      <= in_len;
            st       <= ST_PLAN;
          end
        end
        ST_PLAN: begin
          if (fits) begin
            seg <= rem;
            st  <= ST_OUT;
          end else begin
            dv_n   <= {1'b0, rem} + CHD - DW'(1);
            dv_d   <= CHD;
            dv_r   <= '0;
            dv_cnt <= CW'(DW);
            st     <= ST_CNT;
          end
        end
        ST_CNT: begin
          dv_r   <= r_nx;
          dv_n   <= q_nx;
          dv_cnt <= dv_cnt - CW'(1);
          if (div_done) begin
            dv_n   <= {1'b0, rem};
            dv_d   <= q_nx;
            dv_r   <= '0;
            dv_cnt <= CW'(DW);
            st     <= ST_QUO;
          end
        end
        ST_QUO: begin
          dv_r   <= r_nx;
          dv_n   <= q_nx;
          dv_cnt <= dv_cnt - CW'(1);
          if (div_done) begin
            seg <= q_nx[LW-1:0] & ~AMASK;
            st  <= ST_OUT;
          end
        end
        ST_OUT: begin
          if (out_ready) begin
            cur_addr <= cur_addr + AW'(seg);
            rem      <= rem - seg;
            st       <= out_last ? ST_IDLE : ST_PLAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_ONLY_AFTER_BAD: assert property (@(posedge clk) disable iff (!rst_n)
    err_misalign |-> $past(in_valid && in_ready && (in_addr[ALIGN_BITS-1:0] != '0))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_len) && $stable(out_last)); // R8
  AST_SEG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_len != '0) && ({1'b0, out_len} <= MAXD)); // R9
  AST_MID_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_last |-> (out_len[ALIGN_BITS-1:0] == '0) && (out_addr[ALIGN_BITS-1:0] == '0)); // R9
  AST_BUSY_WHILE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready); // R7
  AST_LAST_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> in_ready && !out_valid); // R7
  AST_MID_NOT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> !in_ready); // R7

endmodule

// File: tb/seg_splitter_tb_top.sv
`timescale 1ns/1ps
module seg_splitter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_addr = '0;
  logic [15:0] in_len = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_addr;
  logic [15:0] out_len;
  logic        out_last;
  logic        err_misalign;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  seg_splitter dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_len(in_len),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_len(out_len), .out_last(out_last), .err_misalign(err_misalign)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int unsigned seg_of(input int unsigned r);
    int unsigned c;
    if (r <= 32'h1FFF) return r;
    c = (r + 32'h1FFC - 1) / 32'h1FFC;
    return (r / c) & ~32'h3;
  endfunction

  task automatic present(input logic [31:0] a, input logic [15:0] l);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    in_addr  = a;
    in_len   = l;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain(input logic [31:0] a, input int unsigned l, input int bp);
    int unsigned ea[64];
    int unsigned el[64];
    int unsigned r = l;
    int unsigned ad = a;
    int n = 0;
    int idx = 0;
    int guard = 0;
    bit held = 0;
    logic [31:0] pa;
    logic [15:0] pl;
    logic plast;
    while (r > 0) begin
      ea[n] = ad; el[n] = seg_of(r);
      ad += el[n]; r -= el[n]; n++;
    end
    while (idx < n && guard < 20000) begin
      if (held)
        chk(out_valid && out_addr == pa && out_len == pl && out_last == plast,
            "R8 hold", {out_valid, out_len}, {1'b1, pl});
      out_ready = ($urandom_range(99) >= bp);
      chk(!in_ready, "R7 busy", in_ready, 0);
      if (out_valid && out_ready) begin
        chk(out_addr == ea[idx], "R6 addr", out_addr, ea[idx]);
        chk(out_len == el[idx], (el[idx] <= 32'h1FFF && idx == n-1) ? "R4 len" : "R5 len",
            out_len, el[idx]);
        chk(out_last == (idx == n-1), "R7 last", out_last, idx == n-1);
        chk(out_len != 0 && out_len <= 16'h1FFF, "R9 range", out_len, el[idx]);
        idx++;
      end
      held = out_valid && !out_ready;
      pa = out_addr; pl = out_len; plast = out_last;
      guard++;
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(idx == n, "R6 count", idx, n);
    chk(in_ready && !out_valid, "R7 release", {in_ready, out_valid}, 2'b10);
  endtask

  task automatic run_req(input logic [31:0] a, input logic [15:0] l, input int bp);
    present(a, l);
    drain(a, l, bp);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !out_valid && !err_misalign, "R1 reset",
        {in_ready, out_valid, err_misalign}, 3'b100);

    // R3: zero length is dropped
    present(32'h1000, 16'd0);
    for (int i = 0; i < 4; i++) begin
      chk(!out_valid && in_ready, "R3 zero", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
    end

    // R2: misaligned alone
    present(32'h2002, 16'd100);
    chk(err_misalign && in_ready && !out_valid, "R2 pulse",
        {err_misalign, in_ready, out_valid}, 3'b110);
    @(negedge clk);
    chk(!err_misalign, "R2 single", err_misalign, 0);
    for (int i = 0; i < 4; i++) begin
      chk(!out_valid && in_ready, "R2 no seg", {out_valid, in_ready}, 2'b01);
      @(negedge clk);
    end

    // R2 with next request accepted while the flag is high
    in_valid = 1'b1; in_addr = 32'h3001; in_len = 16'd40;
    @(negedge clk);
    chk(err_misalign && in_ready, "R2 back2back", {err_misalign, in_ready}, 2'b11);
    in_addr = 32'h4000; in_len = 16'h4000;
    @(negedge clk);
    in_valid = 1'b0;
    chk(!err_misalign, "R2 clear", err_misalign, 0);
    drain(32'h4000, 16'h4000, 30);

    // directed boundaries
    run_req(32'h0000_0100, 16'h1FFF, 0);   // R4 exactly max
    run_req(32'h0000_0200, 16'h2000, 50);  // R5 just above
    run_req(32'h0000_0300, 16'h1FFD, 20);  // R4 odd tail
    run_req(32'hFFFF_F000, 16'hFFFF, 40);  // R5 many pieces, address wrap
    run_req(32'h0000_0400, 16'd1, 70);     // R4 one byte
    run_req(32'h0000_0500, 16'h3FF9, 10);  // R5 odd split

    for (int k = 0; k < 200; k++) begin
      logic [31:0] a;
      logic [15:0] l;
      a = {$urandom() >> 2, 2'b00};
      case ($urandom_range(3))
        0: l = 16'($urandom_range(1, 8191));
        1: l = 16'($urandom_range(8188, 16400));
        default: l = 16'($urandom_range(1, 65535));
      endcase
      if ($urandom_range(9) == 0) begin
        present(a | 32'h1, l);
        chk(err_misalign, "R2 random", err_misalign, 1);
      end else begin
        run_req(a, l, $urandom_range(60));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule